// File: doc/BRIEF.md
# Bus-Master DMA Register Block

This block keeps the bus-master control registers of a two-channel disk controller: a command byte, a status byte and a descriptor-table pointer per channel, plus two spare bytes. The host reaches them through a simple register port. Each access carries a channel index, a byte offset within the channel's 8-byte window, a size code and, for writes, the data. Every access receives a response exactly one cycle later, carrying read data and an error flag.

Two enable inputs gate the port. With I/O decoding off, every access completes with zero data and no effect. With bus mastering off, writes are dropped silently and reads still work. Each channel has a small state machine with two states, `CH_IDLE` and `CH_RUN`. A command write that sets the start bit moves it from CH_IDLE to CH_RUN (transition START) and emits a one-cycle start pulse to the channel's DMA engine. A command write that clears the start bit moves it from CH_RUN to CH_IDLE (transition STOP) and emits a one-cycle stop pulse. Any other command write leaves the state as it is. While a channel is in CH_RUN its transfer direction is frozen. The DMA engine reports back through an active level and error and interrupt set pulses. These land in the status byte.

Top module: `bmide_regs`

## Requirements
- R1: After reset, every register byte of both channels reads 0, both channels are in CH_IDLE, and dma_start, dma_stop, dma_dir, rsp_valid, rsp_rdata and rsp_err are all 0.
- R2: When io_en is 0, an access still gets rsp_valid with rsp_rdata 0 and rsp_err 0, and a write changes no register.
- R3: When io_en is 1 and bm_en is 0, a write changes no register and gives rsp_err 0; reads behave normally.
- R4: A write is legal only as a 1-byte write (size code 0) at offsets 0 to 3, or as a 4-byte write (size code 2) at offset 4. Any other write returns rsp_err 1 and changes nothing.
- R5: A legal write to offset 0 (command) with bit 0 set while the channel is idle pulses dma_start[ch] high for exactly one cycle, in the response cycle. Clearing bit 0 while the channel is running pulses dma_stop[ch] in the same way. Other command writes give no pulse.
- R6: Command bit 3 drives dma_dir[ch]. A command write changes it only while the channel is idle. Command bits 7:4 and 2:1 read as 0.
- R7: Status (offset 2) bit 0 shows dma_active[ch] as sampled one clock earlier. Writes never change it.
- R8: Status bits 1 (error) and 2 (interrupt) are set by a dma_err_set / dma_irq_set pulse and cleared by writing 1 to them. If a set pulse and a clearing write fall in the same cycle, the bit ends up set.
- R9: The descriptor pointer (offsets 4 to 7) stores the written word with bits 1:0 forced to 0.
- R10: Status bits 7:3 and the spare bytes at offsets 1 and 3 store written bytes as they are.
- R11: A read of 1, 2 or 4 bytes (size codes 0, 1, 2) that ends within the 8-byte window returns the bytes little-endian, starting at the offset. A read past byte 7, or with size code 3, returns rsp_err 1 and data 0.
- R12: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and rsp_rdata and rsp_err belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master enable; write gate |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 1 | Channel index |
| req_off | input | 3 | Byte offset in the channel window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data, lowest byte at the offset |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| dma_active | input | 2 | Per-channel engine active level |
| dma_err_set | input | 2 | Per-channel error set pulse |
| dma_irq_set | input | 2 | Per-channel interrupt set pulse |
| dma_start | output | 2 | Per-channel start pulse |
| dma_stop | output | 2 | Per-channel stop pulse |
| dma_dir | output | 2 | Per-channel transfer direction |

## Verification
Two things can fall in the same cycle: an engine set pulse for the error or interrupt bit, and a host write that clears that same bit by writing a 1. The bench provokes this by raising dma_irq_set in exactly the cycle that carries the clearing status write. A following read must show the bit still set. The bench's reference model applies the clear first and the set after it, and the design's status byte is compared with that model every clock.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
    localparam int CHAN_BYTES = 8;
    localparam int OFF_W      = $clog2(CHAN_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } chan_state_e;

    localparam logic [OFF_W-1:0] OFF_CMD = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STS = 3'd2;
    localparam logic [OFF_W-1:0] OFF_PTR = 3'd4;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int STS_ERR = 1;
    localparam int STS_IRQ = 2;
endpackage

// File: rtl/bmide_decode.sv
module bmide_decode
    import bmide_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output logic [2:0]       nbytes,
    output logic             wr_legal,
    output logic             rd_legal,
    output logic             hit_cmd,
    output logic             hit_sts,
    output logic             hit_spare,
    output logic             hit_ptr
);
    logic [OFF_W:0] end_pos;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            SZ_WORD: nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
        end_pos   = {1'b0, off} + {1'b0, nbytes};
        rd_legal  = (nbytes != 3'd0) && (end_pos <= (OFF_W+1)'(CHAN_BYTES));
        wr_legal  = ((size == SZ_BYTE) && (off < OFF_PTR)) ||
                    ((size == SZ_WORD) && (off == OFF_PTR));
        hit_cmd   = (off == OFF_CMD);
        hit_sts   = (off == OFF_STS);
        hit_spare = off[0];
        hit_ptr   = (off == OFF_PTR);
    end
endmodule

// File: rtl/bmide_chan.sv
module bmide_chan
    import bmide_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        sts_we,
    input  logic        spare_we,
    input  logic        spare_hi,
    input  logic        ptr_we,
    input  logic [7:0]  wbyte,
    input  logic [29:0] wptr,
    input  logic        active_in,
    input  logic        err_set,
    input  logic        irq_set,
    output logic [63:0] image,
    output logic        start_pulse,
    output logic        stop_pulse,
    output logic        dir
);
    chan_state_e state, state_nx;
    logic        go, halt;
    logic        act_q, err_q, irq_q;
    logic [4:0]  sts_hi;
    logic [7:0]  spare_lo_q, spare_hi_q;
    logic [29:0] ptr_q;

    // next-state: START (idle -> run), STOP (run -> idle)
    always_comb begin
        state_nx = state;
        go       = 1'b0;
        halt     = 1'b0;
        if (cmd_we) begin
            unique case (state)
                CH_IDLE: if (wbyte[CMD_GO]) begin
                    state_nx = CH_RUN;
                    go       = 1'b1;
                end
                CH_RUN: if (!wbyte[CMD_GO]) begin
                    state_nx = CH_IDLE;
                    halt     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // outputs: pulses and direction (frozen while running)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            dir         <= 1'b0;
        end else begin
            start_pulse <= go;
            stop_pulse  <= halt;
            if (cmd_we && state == CH_IDLE) dir <= wbyte[CMD_DIR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            sts_hi     <= '0;
            spare_lo_q <= '0;
            spare_hi_q <= '0;
            ptr_q      <= '0;
        end else begin
            act_q <= active_in;
            err_q <= err_set | (err_q & ~(sts_we & wbyte[STS_ERR]));
            irq_q <= irq_set | (irq_q & ~(sts_we & wbyte[STS_IRQ]));
            if (sts_we) sts_hi <= wbyte[7:3];
            if (spare_we && !spare_hi) spare_lo_q <= wbyte;
            if (spare_we &&  spare_hi) spare_hi_q <= wbyte;
            if (ptr_we) ptr_q <= wptr;
        end
    end

    assign image = {ptr_q, 2'b00,
                    spare_hi_q,
                    sts_hi, irq_q, err_q, act_q,
                    spare_lo_q,
                    4'b0000, dir, 2'b00, (state == CH_RUN)};
endmodule

// File: rtl/bmide_regs.sv
module bmide_regs
    import bmide_pkg::*;
#(
    parameter int NUM_CHAN = 2,
    parameter int DATA_W   = 32,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_en,
    input  logic                bm_en,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [1:0]          req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    input  logic [NUM_CHAN-1:0] dma_active,
    input  logic [NUM_CHAN-1:0] dma_err_set,
    input  logic [NUM_CHAN-1:0] dma_irq_set,
    output logic [NUM_CHAN-1:0] dma_start,
    output logic [NUM_CHAN-1:0] dma_stop,
    output logic [NUM_CHAN-1:0] dma_dir
);
    logic [2:0]  nbytes;
    logic        wr_legal, rd_legal, hit_cmd, hit_sts, hit_spare, hit_ptr;
    logic        acc_on, wr_go, err_nx;
    logic [63:0] img [NUM_CHAN];
    logic [63:0] shifted;
    logic [DATA_W-1:0] rdata_nx;

    bmide_decode u_dec (
        .off(req_off), .size(req_size), .nbytes(nbytes),
        .wr_legal(wr_legal), .rd_legal(rd_legal),
        .hit_cmd(hit_cmd), .hit_sts(hit_sts),
        .hit_spare(hit_spare), .hit_ptr(hit_ptr)
    );

    assign acc_on = req_valid && io_en;
    assign wr_go  = acc_on && req_write && bm_en && wr_legal;
    assign err_nx = acc_on && (req_write ? (bm_en && !wr_legal) : !rd_legal);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic sel;
        assign sel = wr_go && (req_chan == CHAN_W'(c));
        bmide_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .cmd_we(sel && hit_cmd), .sts_we(sel && hit_sts),
            .spare_we(sel && hit_spare), .spare_hi(req_off[1]),
            .ptr_we(sel && hit_ptr),
            .wbyte(req_wdata[7:0]), .wptr(req_wdata[DATA_W-1:2]),
            .active_in(dma_active[c]), .err_set(dma_err_set[c]),
            .irq_set(dma_irq_set[c]), .image(img[c]),
            .start_pulse(dma_start[c]), .stop_pulse(dma_stop[c]),
            .dir(dma_dir[c])
        );
    end

    always_comb begin
        shifted  = img[req_chan] >> {req_off, 3'b000};
        rdata_nx = '0;
        if (acc_on && !req_write && rd_legal) begin
            unique case (nbytes)
                3'd1:    rdata_nx = {{(DATA_W-8){1'b0}}, shifted[7:0]};
                3'd2:    rdata_nx = {{(DATA_W-16){1'b0}}, shifted[15:0]};
                default: rdata_nx = shifted[DATA_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rdata_nx;
            rsp_err   <= err_nx;
        end
    end
endmodule

module bmide_regs_chk #(
    parameter int NUM_CHAN = 2,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                io_en,
    input logic                bm_en,
    input logic                req_valid,
    input logic                req_write,
    input logic [2:0]          req_off,
    input logic [1:0]          req_size,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                rsp_err,
    input logic [NUM_CHAN-1:0] dma_start,
    input logic [NUM_CHAN-1:0] dma_stop,
    input logic [NUM_CHAN-1:0] dma_dir
);
    logic [NUM_CHAN-1:0] running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) running <= '0;
        else        running <= (running | dma_start) & ~dma_stop;
    end

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_io_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |=> (rsp_rdata == '0 && !rsp_err));
    a_r4_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && io_en && bm_en && req_size != 2'd0 && req_off != 3'd4)
        |=> rsp_err);
    a_r9_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && io_en && req_off == 3'd4 && req_size == 2'd2)
        |=> (rsp_rdata[1:0] == 2'b00));

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
        a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |-> !running[c]);
        a_r5_stop_from_run: assert property (@(posedge clk) disable iff (!rst_n)
            dma_stop[c] |-> running[c]);
        a_r6_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (running[c] && !dma_start[c]) |-> $stable(dma_dir[c]));
    end
endmodule

bind bmide_regs bmide_regs_chk #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/bmide_regs_bench.sv
module bmide_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b1, bm_en = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_chan = 1'b0;
    logic [2:0]  req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  dma_active = '0, dma_err_set = '0, dma_irq_set = '0;
    logic [1:0]  dma_start, dma_stop, dma_dir;

    int    n_chk = 0, n_bad = 0;
    string cur_tag = "R1";
    bit    started = 0;
    logic [1:0]  pend_irq = '0;
    logic [31:0] got_data;
    logic        got_err;
    logic [1:0]  got_start, got_stop;

    // reference model state
    logic [1:0]  m_run = '0, m_dir = '0, m_err = '0, m_irq = '0, m_act = '0;
    logic [7:0]  m_sp1 [2], m_sp3 [2];
    logic [4:0]  m_hi  [2];
    logic [29:0] m_ptr [2];
    logic        e_valid = 0, e_err = 0;
    logic [31:0] e_rdata = '0;
    logic [1:0]  e_start = '0, e_stop = '0;

    always #10 clk = ~clk;

    bmide_regs u_bmide_regs (
        .clk, .rst_n, .io_en, .bm_en, .req_valid, .req_write, .req_chan,
        .req_off, .req_size, .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err,
        .dma_active, .dma_err_set, .dma_irq_set, .dma_start, .dma_stop, .dma_dir
    );

    function automatic logic [7:0] byte_at(int c, int k);
        case (k)
            0: return {4'b0, m_dir[c], 2'b0, m_run[c]};
            1: return m_sp1[c];
            2: return {m_hi[c], m_irq[c], m_err[c], m_act[c]};
            3: return m_sp3[c];
            4: return {m_ptr[c][5:0], 2'b00};
            5: return m_ptr[c][13:6];
            6: return m_ptr[c][21:14];
            default: return m_ptr[c][29:22];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = '0; m_dir = '0; m_err = '0; m_irq = '0; m_act = '0;
            for (int c = 0; c < 2; c++) begin
                m_sp1[c] = '0; m_sp3[c] = '0; m_hi[c] = '0; m_ptr[c] = '0;
            end
            e_valid = 0; e_err = 0; e_rdata = '0; e_start = '0; e_stop = '0;
        end else begin
            int nb, c, o;
            logic [7:0] w;
            nb = (req_size == 0) ? 1 : (req_size == 1) ? 2 : (req_size == 2) ? 4 : 0;
            c = int'(req_chan); o = int'(req_off); w = req_wdata[7:0];
            e_valid = req_valid; e_err = 0; e_rdata = '0; e_start = '0; e_stop = '0;
            if (req_valid && io_en) begin
                if (!req_write) begin
                    if (nb == 0 || o + nb > 8) e_err = 1;
                    else for (int k = 0; k < nb; k++)
                        e_rdata = e_rdata | (32'(byte_at(c, o + k)) << (8 * k));
                end else if (bm_en) begin
                    if (!((nb == 1 && o <= 3) || (nb == 4 && o == 4))) e_err = 1;
                    else if (o == 0) begin
                        if (!m_run[c]) m_dir[c] = w[3];
                        if (!m_run[c] && w[0]) begin m_run[c] = 1; e_start[c] = 1; end
                        else if (m_run[c] && !w[0]) begin m_run[c] = 0; e_stop[c] = 1; end
                    end else if (o == 1) m_sp1[c] = w;
                    else if (o == 3) m_sp3[c] = w;
                    else if (o == 2) begin
                        if (w[1]) m_err[c] = 0;
                        if (w[2]) m_irq[c] = 0;
                        m_hi[c] = w[7:3];
                    end else m_ptr[c] = req_wdata[31:2];
                end
            end
            m_err = m_err | dma_err_set;
            m_irq = m_irq | dma_irq_set;
            m_act = dma_active;
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) if (started) begin
        check({rsp_valid, rsp_err, rsp_rdata, dma_start, dma_stop, dma_dir} ===
              {e_valid, e_err, e_rdata, e_start, e_stop, m_dir},
              cur_tag,
              {rsp_valid, rsp_err, rsp_rdata, dma_start, dma_stop, dma_dir},
              {e_valid, e_err, e_rdata, e_start, e_stop, m_dir});
    end

    task automatic acc(bit wr, bit ch, int off, int sz, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_chan = ch;
        req_off = 3'(off); req_size = 2'(sz); req_wdata = d;
        dma_irq_set = pend_irq;
        @(negedge clk);
        req_valid = 0; dma_irq_set = '0; pend_irq = '0;
        got_data = rsp_rdata; got_err = rsp_err;
        got_start = dma_start; got_stop = dma_stop;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; started = 1;
        check({dma_dir, dma_start, dma_stop, rsp_valid} == 0, "R1 outputs", 64'(dma_dir), 0);
        acc(0, 0, 0, 2, 0); check(got_data == 0, "R1 ch0 low word", got_data, 0);
        acc(0, 1, 4, 2, 0); check(got_data == 0, "R1 ch1 pointer", got_data, 0);
        @(negedge clk);
        check(rsp_valid == 0, "R12 no response when idle", 64'(rsp_valid), 0);

        cur_tag = "R2"; io_en = 0;
        acc(1, 0, 1, 0, 32'hAA);
        acc(0, 0, 1, 0, 0);
        check(got_data == 0 && !got_err, "R2 read while io off", got_data, 0);
        io_en = 1;
        acc(0, 0, 1, 0, 0); check(got_data == 0, "R2 write ignored", got_data, 0);

        cur_tag = "R3"; bm_en = 0;
        acc(1, 0, 1, 0, 32'h55); check(!got_err, "R3 no error", 64'(got_err), 0);
        bm_en = 1;
        acc(0, 0, 1, 0, 0); check(got_data == 0, "R3 write ignored", got_data, 0);

        cur_tag = "R10";
        acc(1, 0, 1, 0, 32'h5A); acc(1, 0, 3, 0, 32'hC3);
        acc(0, 0, 0, 2, 0); check(got_data == 32'hC300_5A00, "R10 spare bytes", got_data, 32'hC300_5A00);
        cur_tag = "R11";
        acc(0, 0, 1, 1, 0); check(got_data == 32'h005A, "R11 halfword at 1", got_data, 32'h005A);
        acc(0, 0, 6, 2, 0); check(got_err && got_data == 0, "R11 past window", {got_err, got_data}, 33'h1_0000_0000);
        acc(0, 0, 0, 3, 0); check(got_err, "R11 bad size code", 64'(got_err), 1);

        cur_tag = "R4";
        acc(1, 0, 0, 1, 32'h0101); check(got_err, "R4 cmd halfword", 64'(got_err), 1);
        acc(1, 0, 2, 2, 32'hFF); check(got_err, "R4 status word", 64'(got_err), 1);
        acc(1, 0, 4, 0, 32'h11); check(got_err, "R4 pointer byte", 64'(got_err), 1);
        acc(1, 0, 5, 0, 32'h11); check(got_err, "R4 pointer middle", 64'(got_err), 1);
        acc(0, 0, 0, 0, 0); check(got_data == 0 && dma_dir == 0, "R4 nothing changed", got_data, 0);

        cur_tag = "R9";
        acc(1, 1, 4, 2, 32'h1234_5677);
        acc(0, 1, 4, 2, 0); check(got_data == 32'h1234_5674, "R9 alignment", got_data, 32'h1234_5674);

        cur_tag = "R5";
        acc(1, 0, 0, 0, 32'h09);
        check(got_start == 2'b01 && got_stop == 0, "R5 start pulse", got_start, 2'b01);
        check(dma_dir == 2'b01, "R6 direction taken while idle", dma_dir, 2'b01);
        @(negedge clk);
        check(dma_start == 0, "R5 pulse one cycle", dma_start, 0);
        cur_tag = "R6";
        acc(1, 0, 0, 0, 32'h01);
        check(got_start == 0 && dma_dir == 2'b01, "R6 direction locked", {got_start, dma_dir}, 4'b0001);
        acc(1, 0, 0, 0, 32'h00);
        check(got_stop == 2'b01 && dma_dir == 2'b01, "R5 stop pulse, R6 still locked", {got_stop, dma_dir}, 4'b0101);
        acc(1, 0, 0, 0, 32'hF6);
        acc(0, 0, 0, 0, 0); check(got_data == 0 && dma_dir == 0, "R6 idle write, reserved bits", got_data, 0);

        cur_tag = "R7"; dma_active = 2'b10;
        acc(0, 1, 2, 0, 0); check(got_data == 32'h01, "R7 active shown", got_data, 1);
        acc(1, 1, 2, 0, 32'h00);
        acc(0, 1, 2, 0, 0); check(got_data == 32'h01, "R7 write keeps active", got_data, 1);
        acc(1, 1, 2, 0, 32'hF8);
        acc(0, 1, 2, 0, 0); check(got_data == 32'hF9, "R10 status high bits", got_data, 32'hF9);
        dma_active = 0;
        acc(0, 1, 2, 0, 0); check(got_data == 32'hF8, "R7 active cleared", got_data, 32'hF8);

        cur_tag = "R8";
        dma_err_set = 2'b01; @(negedge clk); dma_err_set = 0;
        acc(0, 0, 2, 0, 0); check(got_data == 32'h02, "R8 error set", got_data, 2);
        acc(1, 0, 2, 0, 32'h00);
        acc(0, 0, 2, 0, 0); check(got_data == 32'h02, "R8 zero does not clear", got_data, 2);
        acc(1, 0, 2, 0, 32'h02);
        acc(0, 0, 2, 0, 0); check(got_data == 0, "R8 write one clears", got_data, 0);
        dma_irq_set = 2'b01; @(negedge clk); dma_irq_set = 0;
        pend_irq = 2'b01;
        acc(1, 0, 2, 0, 32'h04);
        acc(0, 0, 2, 0, 0); check(got_data == 32'h04, "R8 set wins over clear", got_data, 4);
        acc(1, 0, 2, 0, 32'h04);
        acc(0, 0, 2, 0, 0); check(got_data == 0, "R8 interrupt cleared", got_data, 0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule